// File: doc/BRIEF.md
# Mask-Driven Call Frame Sequencer

This block runs a procedure call and the matching return as multi-cycle sequences. It owns a sixteen-entry register file of 32-bit words. Entries 12 to 15 act as the argument pointer (AP), the frame pointer (FP), the stack pointer (SP) and the program counter (PC). The block reaches memory through a simple synchronous port. A write commits at the clock edge. Read data appears on `mem_rdata` one cycle after the read is issued.

A call names a target address and an argument count. The callee keeps a 16-bit entry mask in the word at the target. Its low twelve bits pick which of R0 to R11 are saved. The sequencer pushes the count, the selected registers, and the linkage words (return PC, caller FP, caller AP, and a word holding the mask and count). It then points FP at the new frame and continues at target+2. A return reads back the linkage word at FP. That word alone decides which registers are restored and how many argument words are dropped. The surrounding pipeline loads and observes registers through a write port and a read port. Both ports are honoured only while the sequencer is idle.

Top module: `call_frame_seq`

## Requirements
- R1: After reset every register reads zero, and `busy`, `done`, `align_fault` and `mem_en` are low.
- R2: A call first reads the word at the target address. Only bits 11:0 of that word are used as the save mask: bit i selects Ri. Bits 31:12 have no effect on what is pushed.
- R3: With SP0 the caller's SP, a call writes these words in this order, each to SP-4 with SP then lowered by 4. First the argument count, zero-extended. Then each selected register from R11 down to R0. Then the caller's PC, the caller's FP and the caller's AP. Last, a linkage word with the count in bits 31:16, the mask in bits 11:0 and zeros in bits 15:12. AP becomes SP0-4.
- R4: When a call completes, FP and SP both equal the address of the linkage word, and PC equals target+2.
- R5: A return loads SP from FP and pops the linkage word, AP, FP and PC. It then pops the registers named by the recovered mask, from R0 up to R11. Registers not in that mask keep their current values.
- R6: A return leaves SP equal to the caller's SP0 plus 4 times the saved argument count, and performs no memory writes.
- R7: Every memory access is a 32-bit word at an address whose two low bits are zero. Each push lowers SP by exactly 4.
- R8: A call whose SP, or a return whose FP, has nonzero low two bits raises `align_fault`. It then finishes in one busy cycle with no memory access and no register change. `align_fault` holds until the next accepted start.
- R9: `done` is a single-cycle pulse in the last busy cycle. With n selected registers, a call is busy for 9+n cycles and a return for 7+n cycles.
- R10: While busy, the register write port and further start requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_start | input | 1 | Begin a call (sampled while idle) |
| call_target | input | 32 | Address of the callee's mask word |
| call_argc | input | 8 | Number of argument words |
| ret_start | input | 1 | Begin a return (sampled while idle; call wins if both) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| align_fault | output | 1 | Last start was refused for stack misalignment |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read |
| rf_we | input | 1 | Register write strobe (idle only) |
| rf_widx | input | 4 | Register write index |
| rf_wdata | input | 32 | Register write data |
| rf_ridx | input | 4 | Register read index |
| rf_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench builds the block with its default parameters: 32-bit words, sixteen registers, a twelve-bit save mask and an eight-bit argument count. With these values the extreme masks (none, all twelve, a sparse pattern) and nonzero and zero counts all fit inside a 256-word bench memory. The scoreboard predicts every pushed address and word from its own model of the register file. The return is then checked against a frame in which registers were deliberately clobbered. That separates restored registers from untouched ones, and the misaligned SP and FP cases exercise the refusal path.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  parameter int unsigned XLEN  = 32;
  parameter int unsigned NREG  = 16;
  parameter int unsigned MASKW = 12;
  parameter int unsigned CNTW  = 8;
  localparam int unsigned IDXW = $clog2(NREG);

  // pointer slots, in register order starting at index 12
  localparam int unsigned PTR_BASE = 12;
  localparam int unsigned PW_AP = 0;
  localparam int unsigned PW_FP = 1;
  localparam int unsigned PW_SP = 2;
  localparam int unsigned PW_PC = 3;

  typedef enum logic [4:0] {
    S_IDLE, S_C_MASK, S_C_ARGC, S_C_REGS, S_C_PC, S_C_FP, S_C_AP, S_C_MW, S_C_FIN,
    S_R_MASK, S_R_AP, S_R_FP, S_R_PC, S_R_REGS, S_R_ARGS, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {P_NONE, P_REG, P_CMASK, P_RMASK} pend_kind_t;

  // linkage word: count in the top half, mask in the low bits
  function automatic logic [XLEN-1:0] link_word(input logic [MASKW-1:0] m, input logic [CNTW-1:0] c);
    logic [XLEN-1:0] w;
    w = '0;
    w[MASKW-1:0] = m;
    w[XLEN-1:XLEN/2] = (XLEN/2)'(c);
    return w;
  endfunction

  function automatic logic [MASKW-1:0] link_mask(input logic [XLEN-1:0] w);
    return w[MASKW-1:0];
  endfunction

  function automatic logic [CNTW-1:0] link_count(input logic [XLEN-1:0] w);
    return w[XLEN/2 +: CNTW];
  endfunction

  // SP after dropping the count word and the argument list
  function automatic logic [XLEN-1:0] release_sp(input logic [XLEN-1:0] sp, input logic [CNTW-1:0] c);
    return sp + ((XLEN'(c) + XLEN'(1)) << 2);
  endfunction
endpackage

// File: rtl/cfs_mask_picker.sv
module cfs_mask_picker #(
  parameter int unsigned W = 12,
  parameter bit HIGH_FIRST = 1'b1,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);
  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) if (mask[i]) idx = IW'(i);
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) if (mask[i]) idx = IW'(i);
      end
    end
  endgenerate

  assign any    = |mask;
  assign onehot = any ? (W'(1) << idx) : '0;
endmodule

// File: rtl/cfs_regfile.sv
module cfs_regfile
  import cfs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_we,
  input  logic [IDXW-1:0]      ext_idx,
  input  logic [XLEN-1:0]      ext_wdata,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [XLEN-1:0]      rd_data,
  input  logic                 pend_we,
  input  logic [IDXW-1:0]      pend_idx,
  input  logic [XLEN-1:0]      pend_wdata,
  input  logic [3:0]           ptr_we,
  input  logic [3:0][XLEN-1:0] ptr_wdata,
  input  logic [IDXW-1:0]      push_idx,
  output logic [XLEN-1:0]      push_data,
  output logic [XLEN-1:0]      ap_q,
  output logic [XLEN-1:0]      fp_q,
  output logic [XLEN-1:0]      sp_q,
  output logic [XLEN-1:0]      pc_q
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q;
    if (g >= PTR_BASE) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (ptr_we[g-PTR_BASE]) q <= ptr_wdata[g-PTR_BASE];
        else if (pend_we && pend_idx == IDXW'(g)) q <= pend_wdata;
        else if (ext_we && ext_idx == IDXW'(g)) q <= ext_wdata;
      end
    end else begin : g_gp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (pend_we && pend_idx == IDXW'(g)) q <= pend_wdata;
        else if (ext_we && ext_idx == IDXW'(g)) q <= ext_wdata;
      end
    end
    assign regs[g] = q;
  end

  assign rd_data   = regs[rd_idx];
  assign push_data = regs[push_idx];
  assign ap_q = regs[PTR_BASE + PW_AP];
  assign fp_q = regs[PTR_BASE + PW_FP];
  assign sp_q = regs[PTR_BASE + PW_SP];
  assign pc_q = regs[PTR_BASE + PW_PC];

  // a popped word never lands on SP: SP is only moved by the sequencer (R5)
  assert_pop_spares_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |-> pend_idx != IDXW'(PTR_BASE + PW_SP));
  // the pipeline port and the sequencer never write in the same cycle (R10)
  assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (ptr_we == 4'b0 && !pend_we));
endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq
  import cfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_start,
  input  logic [31:0]     call_target,
  input  logic [7:0]      call_argc,
  input  logic            ret_start,
  output logic            busy,
  output logic            done,
  output logic            align_fault,
  output logic            mem_en,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            rf_we,
  input  logic [3:0]      rf_widx,
  input  logic [31:0]     rf_wdata,
  input  logic [3:0]      rf_ridx,
  output logic [31:0]     rf_rdata
);
  localparam int unsigned PIW = $clog2(MASKW);

  seq_state_t       state, state_nxt;
  pend_kind_t       pend, pend_nxt;
  logic [IDXW-1:0]  pend_idx, pend_idx_nxt;
  logic [XLEN-1:0]  tgt, old_ap;
  logic [CNTW-1:0]  cnt;
  logic [MASKW-1:0] rem, keep;
  logic             fault;

  logic [3:0]            ptr_we;
  logic [3:0][XLEN-1:0]  ptr_wd;
  logic [IDXW-1:0]       push_idx;
  logic [XLEN-1:0]       push_data, ap_q, fp_q, sp_q, pc_q;

  // named events for the assertions
  logic push_fire, pop_fire, fault_take, accept;
  logic [XLEN-1:0] push_val;

  logic hi_any, lo_any;
  logic [PIW-1:0] hi_idx, lo_idx;
  logic [MASKW-1:0] hi_oh, lo_oh;

  cfs_mask_picker #(.W(MASKW), .HIGH_FIRST(1'b1)) u_hi (.mask(rem), .any(hi_any), .idx(hi_idx), .onehot(hi_oh));
  cfs_mask_picker #(.W(MASKW), .HIGH_FIRST(1'b0)) u_lo (.mask(rem), .any(lo_any), .idx(lo_idx), .onehot(lo_oh));

  cfs_regfile u_rf (
    .clk, .rst_n,
    .ext_we(rf_we && state == S_IDLE), .ext_idx(rf_widx), .ext_wdata(rf_wdata),
    .rd_idx(rf_ridx), .rd_data(rf_rdata),
    .pend_we(pend == P_REG), .pend_idx(pend_idx), .pend_wdata(mem_rdata),
    .ptr_we, .ptr_wdata(ptr_wd),
    .push_idx, .push_data,
    .ap_q, .fp_q, .sp_q, .pc_q
  );

  assign fault_take = (state == S_IDLE) &&
                      ((call_start && sp_q[1:0] != 2'b00) ||
                       (!call_start && ret_start && fp_q[1:0] != 2'b00));
  assign accept = (state == S_IDLE) && (call_start || ret_start);

  always_comb begin
    state_nxt = state; pend_nxt = P_NONE; pend_idx_nxt = '0;
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    ptr_we = '0; ptr_wd = '0; push_idx = '0;
    push_fire = 1'b0; pop_fire = 1'b0; push_val = '0;
    unique case (state)
      S_IDLE: begin
        if (fault_take) state_nxt = S_DONE;
        else if (call_start) state_nxt = S_C_MASK;
        else if (ret_start) state_nxt = S_R_MASK;
      end
      S_C_MASK: begin
        mem_en = 1'b1; mem_addr = {tgt[XLEN-1:2], 2'b00};
        pend_nxt = P_CMASK; state_nxt = S_C_ARGC;
      end
      S_C_ARGC: begin
        push_fire = 1'b1; push_val = XLEN'(cnt);
        ptr_we[PW_AP] = 1'b1; ptr_wd[PW_AP] = sp_q - XLEN'(4);
        state_nxt = S_C_REGS;
      end
      S_C_REGS: begin
        push_idx = IDXW'(hi_idx);
        if (hi_any) begin push_fire = 1'b1; push_val = push_data; end
        else state_nxt = S_C_PC;
      end
      S_C_PC: begin push_fire = 1'b1; push_val = pc_q;   state_nxt = S_C_FP; end
      S_C_FP: begin push_fire = 1'b1; push_val = fp_q;   state_nxt = S_C_AP; end
      S_C_AP: begin push_fire = 1'b1; push_val = old_ap; state_nxt = S_C_MW; end
      S_C_MW: begin push_fire = 1'b1; push_val = link_word(keep, cnt); state_nxt = S_C_FIN; end
      S_C_FIN: begin
        ptr_we[PW_FP] = 1'b1; ptr_wd[PW_FP] = sp_q;
        ptr_we[PW_PC] = 1'b1; ptr_wd[PW_PC] = tgt + XLEN'(2);
        state_nxt = S_DONE;
      end
      S_R_MASK: begin
        mem_en = 1'b1; mem_addr = fp_q;
        ptr_we[PW_SP] = 1'b1; ptr_wd[PW_SP] = fp_q + XLEN'(4);
        pend_nxt = P_RMASK; state_nxt = S_R_AP;
      end
      S_R_AP: begin pop_fire = 1'b1; pend_nxt = P_REG; pend_idx_nxt = IDXW'(PTR_BASE + PW_AP); state_nxt = S_R_FP; end
      S_R_FP: begin pop_fire = 1'b1; pend_nxt = P_REG; pend_idx_nxt = IDXW'(PTR_BASE + PW_FP); state_nxt = S_R_PC; end
      S_R_PC: begin pop_fire = 1'b1; pend_nxt = P_REG; pend_idx_nxt = IDXW'(PTR_BASE + PW_PC); state_nxt = S_R_REGS; end
      S_R_REGS: begin
        if (lo_any) begin pop_fire = 1'b1; pend_nxt = P_REG; pend_idx_nxt = IDXW'(lo_idx); end
        else state_nxt = S_R_ARGS;
      end
      S_R_ARGS: begin
        ptr_we[PW_SP] = 1'b1; ptr_wd[PW_SP] = release_sp(sp_q, cnt);
        state_nxt = S_DONE;
      end
      default: state_nxt = S_IDLE;
    endcase
    if (push_fire) begin
      mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp_q - XLEN'(4); mem_wdata = push_val;
      ptr_we[PW_SP] = 1'b1; ptr_wd[PW_SP] = sp_q - XLEN'(4);
    end
    if (pop_fire) begin
      mem_en = 1'b1; mem_addr = sp_q;
      ptr_we[PW_SP] = 1'b1; ptr_wd[PW_SP] = sp_q + XLEN'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pend <= P_NONE; pend_idx <= '0;
      tgt <= '0; old_ap <= '0; cnt <= '0; rem <= '0; keep <= '0; fault <= 1'b0;
    end else begin
      state <= state_nxt; pend <= pend_nxt; pend_idx <= pend_idx_nxt;
      if (accept) fault <= fault_take;
      if (accept && call_start && !fault_take) begin
        tgt <= call_target; cnt <= call_argc; old_ap <= ap_q;
      end
      if (pend == P_CMASK) begin
        rem <= mem_rdata[MASKW-1:0]; keep <= mem_rdata[MASKW-1:0];
      end else if (pend == P_RMASK) begin
        rem <= link_mask(mem_rdata); cnt <= link_count(mem_rdata);
      end else if (state == S_C_REGS && hi_any) rem <= rem & ~hi_oh;
      else if (state == S_R_REGS && lo_any) rem <= rem & ~lo_oh;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
  assign align_fault = fault;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> mem_addr[1:0] == 2'b00);
  assert_push_step_R7: assert property (@(posedge clk) disable iff (!rst_n) push_fire |=> sp_q == $past(sp_q) - XLEN'(4));
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_en);
  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n) fault_take |=> (done && !mem_en && align_fault));
  assert_frame_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_C_FIN |=> (fp_q == sp_q && pc_q == $past(tgt) + XLEN'(2)));
  assert_ret_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {S_R_MASK, S_R_AP, S_R_FP, S_R_PC, S_R_REGS, S_R_ARGS}) |-> !mem_we);
endmodule

// File: tb/call_frame_seq_tb_top.sv
`timescale 1ns/1ps
module call_frame_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic call_start = 1'b0, ret_start = 1'b0;
  logic [31:0] call_target = '0;
  logic [7:0] call_argc = '0;
  logic busy, done, align_fault, mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata;
  logic rf_we = 1'b0;
  logic [3:0] rf_widx = '0, rf_ridx = '0;
  logic [31:0] rf_wdata = '0;

  always #10 clk = ~clk; // 50 MHz

  call_frame_seq dut_i (.*);

  // word memory model: writes at the edge, reads one cycle later
  logic [31:0] mem [256];
  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    else mem_rdata <= mem[mem_addr[9:2]];
  end

  int checks = 0, failures = 0;
  logic [63:0] exp_q [$];
  logic [31:0] sh [16];     // bench model of the register file
  logic [31:0] caller [16]; // snapshot at the call
  logic [11:0] fr_mask;
  logic [7:0]  fr_argc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every write must match the next predicted push
  always @(negedge clk) if (rst_n && mem_en && mem_we) begin
    logic [63:0] e;
    if (exp_q.size() == 0) chk("R6/R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
    else begin
      e = exp_q.pop_front();
      chk("R3/R7 push addr", mem_addr, e[63:32]);
      chk("R3 push data", mem_wdata, e[31:0]);
    end
  end

  task automatic rd(input int i, output logic [31:0] v);
    rf_ridx = 4'(i); #1; v = rf_rdata;
  endtask

  task automatic wr(input int i, input logic [31:0] v);
    @(negedge clk); rf_we = 1'b1; rf_widx = 4'(i); rf_wdata = v;
    @(negedge clk); rf_we = 1'b0;
    sh[i] = v;
  endtask

  task automatic run(input bit is_call, input bit poke, output int cyc);
    @(negedge clk);
    if (is_call) call_start = 1'b1; else ret_start = 1'b1;
    @(negedge clk);
    call_start = 1'b0; ret_start = 1'b0;
    cyc = 0;
    for (int k = 0; k < 400; k++) begin
      if (busy) cyc++;
      rf_we = poke && (cyc == 3);
      rf_widx = 4'd3; rf_wdata = 32'h5151_5151;
      if (poke && cyc == 4) begin ret_start = 1'b1; call_start = 1'b1; end
      else begin ret_start = 1'b0; call_start = 1'b0; end
      if (done) break;
      @(negedge clk);
    end
    rf_we = 1'b0; call_start = 1'b0; ret_start = 1'b0;
    @(negedge clk);
    chk("R9 done single pulse", 32'(done), 32'd0);
  endtask

  task automatic do_call(input logic [31:0] tgt, input logic [7:0] argc, input logic [15:0] mraw, input bit poke);
    logic [31:0] s, v;
    int cyc, n;
    mem[tgt[9:2]] = {16'hA5C3, mraw}; // bits 31:12 carry junk (R2)
    fr_mask = mraw[11:0]; fr_argc = argc; n = $countones(fr_mask);
    for (int i = 0; i < 16; i++) caller[i] = sh[i];
    s = sh[14] - 4; exp_q.push_back({s, 24'h0, argc});
    for (int i = 11; i >= 0; i--) if (fr_mask[i]) begin s -= 4; exp_q.push_back({s, sh[i]}); end
    s -= 4; exp_q.push_back({s, sh[15]});
    s -= 4; exp_q.push_back({s, sh[13]});
    s -= 4; exp_q.push_back({s, sh[12]});
    s -= 4; exp_q.push_back({s, 8'h0, argc, 4'h0, fr_mask});
    sh[12] = caller[14] - 4; sh[13] = s; sh[14] = s; sh[15] = tgt + 2;
    call_target = tgt; call_argc = argc;
    run(1'b1, poke, cyc);
    chk("R9 call busy cycles", 32'(cyc), 32'(9 + n));
    chk("R3 all pushes seen", 32'(exp_q.size()), 32'd0);
    chk("R8 no fault", 32'(align_fault), 32'd0);
    rd(12, v); chk("R3 AP at count word", v, sh[12]);
    rd(13, v); chk("R4 FP at link word", v, sh[13]);
    rd(14, v); chk("R4 SP equals FP", v, sh[14]);
    rd(15, v); chk("R4 PC target+2", v, sh[15]);
    if (poke) begin rd(3, v); chk("R10 write ignored while busy", v, sh[3]); end
  endtask

  task automatic do_ret();
    logic [31:0] v;
    int cyc;
    for (int i = 0; i < 12; i++) if (fr_mask[i]) sh[i] = caller[i];
    sh[12] = caller[12]; sh[13] = caller[13]; sh[15] = caller[15];
    sh[14] = caller[14] + 4 * fr_argc;
    run(1'b0, 1'b0, cyc);
    chk("R9 return busy cycles", 32'(cyc), 32'(7 + $countones(fr_mask)));
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      if (i == 14) chk("R6 SP released", v, sh[i]);
      else chk("R5 register after return", v, sh[i]);
    end
  endtask

  task automatic clobber();
    for (int i = 0; i < 12; i++) wr(i, 32'hC0DE_0000 | i);
    wr(12, 32'h0000_0777);
    wr(15, 32'h0000_0888);
  endtask

  initial begin
    logic [31:0] v;
    int cyc;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy low", 32'(busy), 0);
    chk("R1 done low", 32'(done), 0);
    chk("R1 fault low", 32'(align_fault), 0);
    chk("R1 mem idle", 32'(mem_en), 0);
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R1 register zero", v, 0); end

    for (int i = 0; i < 12; i++) wr(i, 32'h1000 + 32'h11 * i);
    wr(12, 32'h500); wr(13, 32'h600); wr(14, 32'h3C0); wr(15, 32'h2000);

    // sparse mask, high bits of the mask word set (R2), poke while busy (R10)
    do_call(32'h100, 8'd3, 16'hF0A5, 1'b1);
    clobber();
    do_ret();

    // every register saved, no arguments
    do_call(32'h144, 8'd0, 16'h0FFF, 1'b0);
    clobber();
    do_ret();

    // nothing saved, odd target
    do_call(32'h182, 8'd2, 16'h3000, 1'b0);
    clobber();
    do_ret();

    // misaligned SP on call (R8)
    wr(14, 32'h3C2);
    call_target = 32'h100; call_argc = 8'd1;
    run(1'b1, 1'b0, cyc);
    chk("R8 call fault busy", 32'(cyc), 1);
    chk("R8 call fault flag", 32'(align_fault), 1);
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R8 registers untouched", v, sh[i]); end
    // misaligned FP on return (R8)
    wr(14, 32'h3C0); wr(13, 32'h605);
    run(1'b0, 1'b0, cyc);
    chk("R8 return fault busy", 32'(cyc), 1);
    chk("R8 return fault flag", 32'(align_fault), 1);
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R8 registers untouched", v, sh[i]); end
    // a good call clears the flag
    wr(13, 32'h600);
    do_call(32'h1C0, 8'd1, 16'h0801, 1'b0);
    do_ret();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule